// File: doc/BRIEF.md
# Two-Register ALU with Condition Flags

This block is the execute stage for the register-to-register data-processing group of a 16-bit compressed instruction set. Each operation takes a 4-bit opcode, a destination operand, a source operand and the current N, Z, C and V flags. It returns a 32-bit result, a write-enable for the destination register, the updated flags and the number of execution cycles the operation costs. Register fetch, decode and memory access are handled elsewhere.

An operation starts when `in_valid` is high and `in_ready` is high. The answer appears on the output side with `out_valid` and stays there until `out_ready` takes it. Most operations finish at once. Shifts by a register amount spend one extra internal cycle. The multiply runs one 8-bit multiplier digit per cycle and stops early when the upper bits of the multiplier are pure sign fill, so its cost depends on the multiplier value.

Top module: `rr_alu`

## Requirements
- R1: Opcode encoding (op_i): 0 AND, 1 EOR, 2 LSL, 3 LSR, 4 ASR, 5 ADC, 6 SBC, 7 ROR, 8 TST, 9 NEG, 10 CMP, 11 CMN, 12 ORR, 13 MUL, 14 BIC, 15 MVN. Flags on flags_i and flags_o are packed {N,Z,C,V}, with N at bit 3 and V at bit 0. AND, EOR and ORR give the bitwise result. BIC gives dst AND NOT src. MVN gives NOT src. Each of them sets N from result bit 31, sets Z when the result is zero, and passes C and V through unchanged.
- R2: ADC returns dst + src + C. SBC returns dst - src - (NOT C). C is the carry out of the 32-bit sum; for a subtraction, C=1 means no borrow occurred. V is set on signed overflow. N and Z come from the result.
- R3: NEG returns 0 - src, CMP computes dst - src and CMN computes dst + src. All three use the same N, Z, C and V rules as R2.
- R4: TST (flags from dst AND src), CMP and CMN return wr_o=0. Every other opcode returns wr_o=1.
- R5: LSL and LSR shift dst by src[7:0]. An amount of 0 leaves the value and C unchanged. Amounts 1 to 31 shift normally, and C takes the last bit shifted out. An amount of 32 gives zero, with C = dst[0] for LSL and C = dst[31] for LSR. An amount above 32 gives zero and C=0.
- R6: ASR by src[7:0]. An amount of 0 leaves the value and C unchanged. Amounts 1 to 31 shift with sign fill, and C takes the last bit shifted out. An amount of 32 or more fills every bit with dst[31], and C = dst[31].
- R7: ROR rotates dst right by src[7:0] modulo 32. Any nonzero amount, including multiples of 32, sets C to bit 31 of the result. An amount of 0 leaves the value and C unchanged. No shift or rotate changes V.
- R8: MUL returns the low 32 bits of dst x src. N and Z come from that value, and C and V pass through unchanged.
- R9: cyc_o is 1 for most opcodes, 2 for LSL, LSR, ASR and ROR, and 1+m for MUL. The value of m is 1, 2 or 3 when src[31:8], src[31:16] or src[31:24] (the first that qualifies) is all zeros or all ones, and 4 otherwise. Counting the accepting rising edge as edge 1, out_valid first goes high after edge number cyc_o.
- R10: in_ready is high only while no operation is in progress or waiting. While out_valid is high and out_ready is low, every output holds its value. In the cycle after the edge where out_valid and out_ready are both high, in_ready is high again.
- R11: During reset and directly after it, in_ready=1 and out_valid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation request |
| in_ready | output | 1 | Unit can accept an operation |
| op_i | input | 4 | Opcode (encoding in R1) |
| dst_i | input | 32 | Destination register value (first operand) |
| src_i | input | 32 | Source register value (second operand / shift amount / multiplier) |
| flags_i | input | 4 | Current {N,Z,C,V} |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| res_o | output | 32 | Result value |
| wr_o | output | 1 | Destination write-enable |
| flags_o | output | 4 | Updated {N,Z,C,V} |
| cyc_o | output | 3 | Execution cycle cost of the operation |

## Verification
Results arrive after a number of clock edges that depends on the opcode, so the bench measures that distance for every operation. After the accepting edge it looks at out_valid at each following falling edge and counts the edges until out_valid appears. That count must equal the cycle cost it computes itself: 1 for plain operations, 2 for register shifts, and 1+m for a multiply, with m taken from the magnitude band of the multiplier. The result, write-enable and flags are compared only at the falling edge where out_valid is first seen, and again while it is held under back-pressure. in_ready is checked one edge after the release.

// File: rtl/rr_alu_pkg.sv
package rr_alu_pkg;

    typedef enum logic [3:0] {
        OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_LSL = 4'd2,  OP_LSR = 4'd3,
        OP_ASR = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_ROR = 4'd7,
        OP_TST = 4'd8,  OP_NEG = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
        OP_ORR = 4'd12, OP_MUL = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
    } alu_op_e;

    typedef enum logic [1:0] {
        SH_LSL = 2'd0,
        SH_LSR = 2'd1,
        SH_ASR = 2'd2,
        SH_ROR = 2'd3
    } sh_kind_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_WAIT = 2'd1,
        PH_MUL  = 2'd2,
        PH_DONE = 2'd3
    } phase_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

endpackage

// File: rtl/rr_alu_shift.sv
module rr_alu_shift
    import rr_alu_pkg::*;
#(
    parameter int unsigned DW = 32,
    localparam int unsigned AW = $clog2(DW)
) (
    input  sh_kind_e        kind_i,
    input  logic [DW-1:0]   val_i,
    input  logic [7:0]      amt_i,
    input  logic            c_i,
    output logic [DW-1:0]   res_o,
    output logic            c_o
);

    logic [AW-1:0]      sh;
    logic               amt_zero;
    logic               amt_eq;
    logic               amt_big;
    logic [DW:0]        wide_l;
    logic [DW:0]        wide_r;
    logic signed [DW:0] wide_a;
    logic [2*DW-1:0]    dbl;

    assign sh       = amt_i[AW-1:0];
    assign amt_zero = (amt_i == 8'd0);
    assign amt_eq   = (32'(amt_i) == DW);
    assign amt_big  = (32'(amt_i) > DW);

    always_comb begin
        wide_l = {1'b0, val_i} << sh;
        wide_r = {val_i, 1'b0} >> sh;
        wide_a = $signed({val_i, 1'b0}) >>> sh;
        dbl    = {val_i, val_i} >> sh;
        res_o  = val_i;
        c_o    = c_i;
        if (!amt_zero) begin
            unique case (kind_i)
                SH_LSL: begin
                    if (amt_eq) begin
                        res_o = '0;
                        c_o   = val_i[0];
                    end else if (amt_big) begin
                        res_o = '0;
                        c_o   = 1'b0;
                    end else begin
                        res_o = wide_l[DW-1:0];
                        c_o   = wide_l[DW];
                    end
                end
                SH_LSR: begin
                    if (amt_eq) begin
                        res_o = '0;
                        c_o   = val_i[DW-1];
                    end else if (amt_big) begin
                        res_o = '0;
                        c_o   = 1'b0;
                    end else begin
                        res_o = wide_r[DW:1];
                        c_o   = wide_r[0];
                    end
                end
                SH_ASR: begin
                    if (amt_eq || amt_big) begin
                        res_o = {DW{val_i[DW-1]}};
                        c_o   = val_i[DW-1];
                    end else begin
                        res_o = wide_a[DW:1];
                        c_o   = wide_a[0];
                    end
                end
                SH_ROR: begin
                    res_o = dbl[DW-1:0];
                    c_o   = dbl[DW-1];
                end
                default: begin
                    res_o = val_i;
                    c_o   = c_i;
                end
            endcase
        end
    end

endmodule

// File: rtl/rr_alu_addsub.sv
module rr_alu_addsub #(
    parameter int unsigned DW = 32
) (
    input  logic [DW-1:0] x_i,
    input  logic [DW-1:0] y_i,
    input  logic          cin_i,
    output logic [DW-1:0] sum_o,
    output logic          c_o,
    output logic          v_o
);

    logic [DW:0] total;

    always_comb begin
        total = {1'b0, x_i} + {1'b0, y_i} + {{DW{1'b0}}, cin_i};
        sum_o = total[DW-1:0];
        c_o   = total[DW];
        v_o   = (x_i[DW-1] == y_i[DW-1]) && (total[DW-1] != x_i[DW-1]);
    end

endmodule

// File: rtl/rr_alu_mul.sv
module rr_alu_mul #(
    parameter int unsigned DW    = 32,
    parameter int unsigned CHUNK = 8,
    localparam int unsigned STEPS = DW / CHUNK,
    localparam int unsigned SW    = $clog2(STEPS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [DW-1:0] mcand_i,
    input  logic [DW-1:0] mplier_i,
    output logic [SW-1:0] steps_o,
    output logic          done_o,
    output logic [DW-1:0] prod_o
);

    typedef struct packed {
        logic          active;
        logic [SW-1:0] idx;
        logic [SW-1:0] m;
        logic          neg;
        logic [DW-1:0] acc;
        logic [DW-1:0] a;
        logic [DW-1:0] b;
    } mul_st_t;

    mul_st_t q, d;

    logic [STEPS-1:1] fit;
    logic [DW-1:0]    digit;
    logic [DW-1:0]    part;
    logic [DW-1:0]    sum;
    logic             last;

    // a band qualifies when the bits above it are pure zero or pure one fill
    for (genvar k = 1; k < STEPS; k++) begin : g_fit
        assign fit[k] = (~|mplier_i[DW-1:k*CHUNK]) | (&mplier_i[DW-1:k*CHUNK]);
    end

    always_comb begin
        steps_o = SW'(STEPS);
        for (int k = STEPS - 1; k >= 1; k--) begin
            if (fit[k]) steps_o = SW'(k);
        end
    end

    always_comb begin
        d      = q;
        digit  = DW'(q.b[q.idx*CHUNK +: CHUNK]);
        part   = (q.a * digit) << (q.idx * CHUNK);
        sum    = q.acc + part;
        last   = (q.idx == q.m - SW'(1));
        if (last && q.neg && (32'(q.m) < STEPS)) begin
            sum = sum - (q.a << (q.m * CHUNK));
        end
        done_o = q.active && last;
        prod_o = sum;
        if (start_i) begin
            d.active = 1'b1;
            d.idx    = '0;
            d.m      = steps_o;
            d.neg    = mplier_i[DW-1];
            d.acc    = '0;
            d.a      = mcand_i;
            d.b      = mplier_i;
        end else if (q.active) begin
            d.acc = sum;
            d.idx = q.idx + SW'(1);
            if (last) d.active = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R8
    mul_start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !q.active);

    // R9
    mul_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> q.active && (q.idx == '0));

endmodule

// File: rtl/rr_alu.sv
module rr_alu
    import rr_alu_pkg::*;
#(
    parameter int unsigned DW    = 32,
    parameter int unsigned CHUNK = 8,
    localparam int unsigned STEPS = DW / CHUNK,
    localparam int unsigned SW    = $clog2(STEPS + 1),
    localparam int unsigned CW    = $clog2(STEPS + 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [3:0]    op_i,
    input  logic [DW-1:0] dst_i,
    input  logic [DW-1:0] src_i,
    input  logic [3:0]    flags_i,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [DW-1:0] res_o,
    output logic          wr_o,
    output logic [3:0]    flags_o,
    output logic [CW-1:0] cyc_o
);

    typedef struct packed {
        phase_e        ph;
        logic [DW-1:0] res;
        logic          wr;
        nzcv_t         flg;
        logic [CW-1:0] cyc;
    } st_t;

    st_t q, d;

    alu_op_e       op;
    nzcv_t         fin;
    logic          accept;
    logic          is_shift;
    logic          is_nowr;

    sh_kind_e      sh_kind;
    logic [DW-1:0] sh_res;
    logic          sh_c;

    logic [DW-1:0] as_x, as_y, as_sum;
    logic          as_cin, as_c, as_v;

    logic          mul_done;
    logic [DW-1:0] mul_prod;
    logic [SW-1:0] mul_m;

    logic [DW-1:0] lres;
    logic          lwr;
    nzcv_t         lflg;

    assign op       = alu_op_e'(op_i);
    assign fin      = nzcv_t'(flags_i);
    assign accept   = in_valid && (q.ph == PH_IDLE);
    assign is_shift = (op == OP_LSL) || (op == OP_LSR) || (op == OP_ASR) || (op == OP_ROR);
    assign is_nowr  = (op == OP_TST) || (op == OP_CMP) || (op == OP_CMN);

    // operand steering for the shifter and the adder
    always_comb begin
        as_x    = dst_i;
        as_y    = src_i;
        as_cin  = 1'b0;
        sh_kind = SH_LSL;
        unique case (op)
            OP_ADC: as_cin = fin.c;
            OP_SBC: begin as_y = ~src_i; as_cin = fin.c; end
            OP_CMP: begin as_y = ~src_i; as_cin = 1'b1;  end
            OP_NEG: begin as_x = '0; as_y = ~src_i; as_cin = 1'b1; end
            OP_LSR: sh_kind = SH_LSR;
            OP_ASR: sh_kind = SH_ASR;
            OP_ROR: sh_kind = SH_ROR;
            default: ;
        endcase
    end

    rr_alu_shift #(.DW(DW)) u_shift (
        .kind_i (sh_kind),
        .val_i  (dst_i),
        .amt_i  (src_i[7:0]),
        .c_i    (fin.c),
        .res_o  (sh_res),
        .c_o    (sh_c)
    );

    rr_alu_addsub #(.DW(DW)) u_addsub (
        .x_i   (as_x),
        .y_i   (as_y),
        .cin_i (as_cin),
        .sum_o (as_sum),
        .c_o   (as_c),
        .v_o   (as_v)
    );

    rr_alu_mul #(.DW(DW), .CHUNK(CHUNK)) u_mul (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (accept && (op == OP_MUL)),
        .mcand_i  (dst_i),
        .mplier_i (src_i),
        .steps_o  (mul_m),
        .done_o   (mul_done),
        .prod_o   (mul_prod)
    );

    always_comb begin
        d    = q;
        lres = '0;
        lwr  = !is_nowr;
        lflg = fin;
        unique case (op)
            OP_AND, OP_TST: lres = dst_i & src_i;
            OP_EOR:         lres = dst_i ^ src_i;
            OP_ORR:         lres = dst_i | src_i;
            OP_BIC:         lres = dst_i & ~src_i;
            OP_MVN:         lres = ~src_i;
            OP_LSL, OP_LSR, OP_ASR, OP_ROR: begin
                lres   = sh_res;
                lflg.c = sh_c;
            end
            OP_ADC, OP_SBC, OP_NEG, OP_CMP, OP_CMN: begin
                lres   = as_sum;
                lflg.c = as_c;
                lflg.v = as_v;
            end
            default: lres = '0;
        endcase
        lflg.n = lres[DW-1];
        lflg.z = (lres == '0);

        unique case (q.ph)
            PH_IDLE: begin
                if (accept) begin
                    d.res = lres;
                    d.wr  = lwr;
                    d.flg = lflg;
                    if (op == OP_MUL) begin
                        d.ph  = PH_MUL;
                        d.flg = fin;
                        d.cyc = CW'(mul_m) + CW'(1);
                    end else if (is_shift) begin
                        d.ph  = PH_WAIT;
                        d.cyc = CW'(2);
                    end else begin
                        d.ph  = PH_DONE;
                        d.cyc = CW'(1);
                    end
                end
            end
            PH_WAIT: d.ph = PH_DONE;
            PH_MUL: begin
                if (mul_done) begin
                    d.res   = mul_prod;
                    d.flg.n = mul_prod[DW-1];
                    d.flg.z = (mul_prod == '0);
                    d.ph    = PH_DONE;
                end
            end
            PH_DONE: if (out_ready) d.ph = PH_IDLE;
            default: d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign in_ready  = (q.ph == PH_IDLE);
    assign out_valid = (q.ph == PH_DONE);
    assign res_o     = q.res;
    assign wr_o      = q.wr;
    assign flags_o   = q.flg;
    assign cyc_o     = q.cyc;

    // R10
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(res_o) && $stable(flags_o) && $stable(wr_o));

    // R10
    release_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready |=> in_ready);

    // R9
    single_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !is_shift && (op != OP_MUL) |=> out_valid);

    // R9
    shift_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept && is_shift |=> !out_valid ##1 out_valid);

    // R4
    nowr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept && is_nowr |=> !wr_o);

    // R8
    mul_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mul_done |-> (q.ph == PH_MUL));

endmodule

// File: tb/sim_rr_alu.sv
`timescale 1ns/1ps
module sim_rr_alu;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [3:0]  op_i = '0;
    logic [31:0] dst_i = '0;
    logic [31:0] src_i = '0;
    logic [3:0]  flags_i = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] res_o;
    logic        wr_o;
    logic [3:0]  flags_o;
    logic [2:0]  cyc_o;

    int tests = 0;
    int fails = 0;
    int wd = 0;

    always #2 clk = ~clk;

    rr_alu u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .op_i(op_i), .dst_i(dst_i), .src_i(src_i), .flags_i(flags_i),
        .out_valid(out_valid), .out_ready(out_ready), .res_o(res_o),
        .wr_o(wr_o), .flags_o(flags_o), .cyc_o(cyc_o)
    );

    task automatic check(input logic ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            tests++;
            fails++;
            $display("FAIL R9 watchdog expired: actual %0d expected %0d", wd, 150000);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    function automatic string tag_of(input logic [3:0] op);
        case (op)
            4'd5, 4'd6:          return "R2";
            4'd9, 4'd10, 4'd11:  return "R3";
            4'd8:                return "R4";
            4'd2, 4'd3:          return "R5";
            4'd4:                return "R6";
            4'd7:                return "R7";
            4'd13:               return "R8";
            default:             return "R1";
        endcase
    endfunction

    function automatic int mul_steps(input logic [31:0] b);
        if (b < 32'h0000_0100 || b >= 32'hFFFF_FF00) return 1;
        if (b < 32'h0001_0000 || b >= 32'hFFFF_0000) return 2;
        if (b < 32'h0100_0000 || b >= 32'hFF00_0000) return 3;
        return 4;
    endfunction

    function automatic void model(input logic [3:0] op, input logic [31:0] a,
                                  input logic [31:0] b, input logic [3:0] f,
                                  output logic [31:0] r, output logic w,
                                  output logic [3:0] fo, output int cyc);
        logic n, z, c, v, cin;
        longint ua, ub, sa, sb, s, s2, xs;
        logic [63:0] x;
        int amt, k, bor;
        {n, z, c, v} = f;
        cin = c;
        w = 1'b1;
        cyc = 1;
        r = '0;
        ua = longint'({32'b0, a});
        ub = longint'({32'b0, b});
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        amt = int'(b[7:0]);
        case (op)
            4'd0:  r = a & b;
            4'd1:  r = a ^ b;
            4'd12: r = a | b;
            4'd14: r = a & ~b;
            4'd15: r = ~b;
            4'd8:  begin r = a & b; w = 1'b0; end
            4'd5, 4'd11: begin
                if (op == 4'd11) begin cin = 1'b0; w = 1'b0; end
                s  = ua + ub + longint'(cin);
                s2 = sa + sb + longint'(cin);
                r  = s[31:0];
                c  = s[32];
                v  = (s2 > 64'sd2147483647) || (s2 < -64'sd2147483648);
            end
            4'd6, 4'd10: begin
                bor = (op == 4'd10) ? 0 : (cin ? 0 : 1);
                if (op == 4'd10) w = 1'b0;
                s  = ua - ub - longint'(bor);
                s2 = sa - sb - longint'(bor);
                r  = s[31:0];
                c  = (ua >= ub + longint'(bor));
                v  = (s2 > 64'sd2147483647) || (s2 < -64'sd2147483648);
            end
            4'd9: begin
                s2 = -sb;
                r  = 32'd0 - b;
                c  = (b == 32'd0);
                v  = (s2 > 64'sd2147483647);
            end
            4'd2: begin
                x = {32'b0, a} << amt;
                r = x[31:0];
                if (amt != 0) c = x[32];
                cyc = 2;
            end
            4'd3: begin
                x = {a, 32'b0} >> amt;
                r = x[63:32];
                if (amt != 0) c = x[31];
                cyc = 2;
            end
            4'd4: begin
                xs = $signed({a, 32'b0}) >>> amt;
                r = xs[63:32];
                if (amt != 0) c = xs[31];
                cyc = 2;
            end
            4'd7: begin
                k = amt % 32;
                r = (a >> k) | (a << (32 - k));
                if (amt != 0) c = r[31];
                cyc = 2;
            end
            default: begin
                r = a * b;
                cyc = 1 + mul_steps(b);
            end
        endcase
        n = r[31];
        z = (r == 32'd0);
        fo = {n, z, c, v};
    endfunction

    task automatic run_op(input logic [3:0] op, input logic [31:0] a,
                          input logic [31:0] b, input logic [3:0] f, input int hold);
        logic [31:0] er, sr;
        logic        ew;
        logic [3:0]  ef;
        int          ec, lat;
        string       t;
        model(op, a, b, f, er, ew, ef, ec);
        t = tag_of(op);
        op_i = op; dst_i = a; src_i = b; flags_i = f; in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        lat = 1;
        @(negedge clk);
        in_valid = 1'b0;
        while (!out_valid && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        // R9 latency and reported cost
        check(lat == ec, "R9", "latency", lat, ec);
        check(32'(cyc_o) == ec, "R9", "cycle count", 32'(cyc_o), ec);
        check(wr_o == ew, "R4", "write enable", 32'(wr_o), 32'(ew));
        check(flags_o == ef, t, "flags", 32'(flags_o), 32'(ef));
        if (ew) check(res_o == er, t, "result", res_o, er);
        sr = res_o;
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            check(out_valid && !in_ready && res_o == sr, "R10", "held output", res_o, sr);
        end
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        check(in_ready && !out_valid, "R10", "ready after release", 32'(in_ready), 32'd1);
    endtask

    localparam int NA = 8;
    localparam int NB = 16;
    logic [31:0] av [NA] = '{32'h0, 32'h1, 32'h7FFF_FFFF, 32'h8000_0000,
                             32'hFFFF_FFFF, 32'd328940001, 32'hDEAD_BEEF, 32'h0000_0100};
    logic [31:0] bv [NB] = '{32'd0, 32'd1, 32'd5, 32'd31, 32'd32, 32'd33, 32'hFF, 32'h100,
                             32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF, 32'hFFFF_FC21,
                             32'h00AB_CDEF, 32'h1234_5678, 32'h0000_FF00, 32'hFFFF_FF05};
    logic [3:0]  fv [4]  = '{4'b0000, 4'b0010, 4'b1101, 4'b1111};

    initial begin
        // R11 reset state
        @(negedge clk);
        check(in_ready == 1'b1, "R11", "in_ready in reset", 32'(in_ready), 32'd1);
        check(out_valid == 1'b0, "R11", "out_valid in reset", 32'(out_valid), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready && !out_valid, "R11", "idle after reset", 32'(in_ready), 32'd1);

        // R10 back-pressure on a single-cycle, a shift and a multiply
        run_op(4'd0, 32'hF0F0_1234, 32'h0FF0_FFFF, 4'b0011, 3);
        run_op(4'd4, 32'h8000_0010, 32'd40, 4'b0000, 2);
        run_op(4'd13, 32'd328940001, 32'hFFFF_FC21, 4'b0011, 4);

        // full sweep: every opcode against operand and flag patterns
        for (int op = 0; op < 16; op++)
            for (int ia = 0; ia < NA; ia++)
                for (int ib = 0; ib < NB; ib++)
                    for (int iflag = 0; iflag < 4; iflag++)
                        run_op(4'(op), av[ia], bv[ib], fv[iflag], 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule